// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a three-wire link to a 12-bit serial converter. It takes one request at a time over a valid/ready port. Each request carries a 12-bit output code and a 2-bit operating mode. The block turns the request into a 16-bit command, most significant bit first, on a strobe, a serial clock and a data line.

The command goes out as two 8-bit transfers from a byte engine, with the strobe held low across both. The serial clock idles low. Data changes on the rising edge and is sampled by the receiver on the falling edge.

Three parameters, counted in system clocks, set timing:
- the high phase of the serial clock;
- the low phase of the serial clock;
- the minimum time the strobe stays high before a frame.

An `idle_low` input lets the strobe rest low after a frame to save power. In that case the next frame first pulses the strobe high for the minimum time.

A build parameter selects a byte engine that shifts least significant bit first. The sequencer then bit-reverses each byte, so the line waveform does not change. An `abort` input ends a frame at once. This leaves the receiver with a short, discarded frame.

Top module: `dacw_seq`

## Requirements
- R1: While reset is held, `ser_cs_n` is 1, `ser_clk` is 0, `req_ready` is 1 and `done` is 0.
- R2: The 16 bits seen on `ser_dat` at falling `ser_clk` edges are, in order: 0, 0, `req_mode[1]`, `req_mode[0]`, then `req_code[11]` down to `req_code[0]`.
- R3: One frame gives exactly 16 falling `ser_clk` edges, sent as two 8-bit transfers, and `ser_cs_n` stays low from the first rising edge through the sixteenth falling edge. `ser_clk` rises only while `ser_cs_n` is low.
- R4: `ser_clk` is 0 whenever `ser_cs_n` is 1, and `ser_dat` does not change in the cycle `ser_clk` falls.
- R5: Inside a frame, every `ser_clk` high phase lasts at least `HI_CYC` system clocks, and every low phase between two bits lasts at least `LO_CYC`.
- R6: Before every falling edge of `ser_cs_n`, the strobe has been high for at least `GAP_CYC` system clocks.
- R7: When `idle_low` is 1 at the end of a frame, `ser_cs_n` stays low afterwards. The next frame raises it for at least `GAP_CYC` clocks before lowering it. When `idle_low` is 0, `ser_cs_n` returns high at the end of the frame.
- R8: With `LSB_ENGINE`=1, the outputs `ser_cs_n`, `ser_clk` and `ser_dat` match those of the `LSB_ENGINE`=0 build cycle for cycle.
- R9: A request is accepted in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the next cycle until the cycle in which `done` is 1.
- R10: `abort` while busy sets `ser_cs_n` to 1 and `ser_clk` to 0 and returns `req_ready` to 1, all in the next cycle, with no `done` pulse. `abort` while idle has no effect on the outputs.
- R11: `done` is a single-cycle pulse, given once for each frame that completes all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_code | input | 12 | Converter output code |
| req_mode | input | 2 | Operating mode bits |
| idle_low | input | 1 | Leave strobe low after the frame |
| abort | input | 1 | End the current frame at once |
| ser_cs_n | output | 1 | Frame strobe, active low |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data, valid at falling clock edges |
| done | output | 1 | One-cycle pulse per completed frame |

## Verification
Some properties are checked on every cycle:
- the clock-idle and data-stability rules;
- the minimum clock high and low widths, measured with run counters in the byte engine;
- the strobe-high time before each frame start;
- the ready drop after acceptance;
- the abort release and the single-cycle `done`.

Other behaviour shows only in the bench's scenarios. The bench decodes the received words from the line, covers idle-low frames following each other, and counts the discarded partial frame after an abort. It also compares the mirrored-engine build with the plain build.

// File: rtl/dacw_pkg.sv
`timescale 1ns/1ps
package dacw_pkg;
  localparam int CODE_W = 12;
  localparam int MODE_W = 2;
  localparam int CMD_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_B0, S_B1} seq_st_t;

  // command word: two zero pad bits, mode, code
  function automatic logic [CMD_W-1:0] pack_cmd(input logic [MODE_W-1:0] mode,
                                                input logic [CODE_W-1:0] code);
    return {2'b00, mode, code};
  endfunction

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/dacw_byte_tx.sv
`timescale 1ns/1ps
module dacw_byte_tx #(
  parameter int HI_CYC    = 2,
  parameter int LO_CYC    = 3,
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kill,
  input  logic       start,
  input  logic [7:0] byte_in,
  output logic       sclk,
  output logic       sdat,
  output logic       fin
);
  localparam int CW = $clog2(HI_CYC + LO_CYC + 1);
  localparam int RW = $clog2(HI_CYC + LO_CYC + 2);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [7:0]    sh, sh_nxt;
  logic [2:0]    bit_idx;
  logic [CW-1:0] cnt;
  logic          in_hi, busy, sclk_q, fin_q;

  // shift direction picked by the engine variant
  generate
    if (LSB_FIRST) begin : g_lsb
      assign sdat   = sh[0];
      assign sh_nxt = {1'b0, sh[7:1]};
    end else begin : g_msb
      assign sdat   = sh[7];
      assign sh_nxt = {sh[6:0], 1'b0};
    end
  endgenerate

  wire hi_end  = busy && in_hi  && (cnt == CW'(HI_CYC - 1));
  wire lo_end  = busy && !in_hi && (cnt == CW'(LO_CYC - 1));
  wire last_bt = (bit_idx == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; bit_idx <= '0; cnt <= '0;
      in_hi <= 1'b0; busy <= 1'b0; sclk_q <= 1'b0; fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (kill) begin
        busy <= 1'b0; sclk_q <= 1'b0; sh <= '0;
      end else if (start && !busy) begin
        sh <= byte_in; sclk_q <= 1'b1; in_hi <= 1'b1;
        cnt <= '0; bit_idx <= '0; busy <= 1'b1;
      end else if (hi_end) begin
        sclk_q <= 1'b0; in_hi <= 1'b0; cnt <= '0;
      end else if (lo_end) begin
        if (last_bt) begin
          busy <= 1'b0; fin_q <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 3'd1; sh <= sh_nxt;
          sclk_q <= 1'b1; in_hi <= 1'b1; cnt <= '0;
        end
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign sclk = sclk_q;
  assign fin  = fin_q;

  // run-length observers for the width properties
  logic [RW-1:0] hi_run, lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0; lo_run <= '0;
    end else begin
      hi_run <= sclk_q  ? ((hi_run == RMAX) ? RMAX : hi_run + RW'(1)) : '0;
      lo_run <= !sclk_q ? ((lo_run == RMAX) ? RMAX : lo_run + RW'(1)) : '0;
    end
  end

  p_hi_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) && !$past(kill) |-> hi_run >= RW'(HI_CYC));
  p_lo_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) && bit_idx != 3'd0 |-> lo_run >= RW'(LO_CYC));
  p_dat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> $stable(sdat));
endmodule

// File: rtl/dacw_seq.sv
`timescale 1ns/1ps
module dacw_seq
  import dacw_pkg::*;
#(
  parameter int HI_CYC     = 2,
  parameter int LO_CYC     = 3,
  parameter int GAP_CYC    = 7,
  parameter bit LSB_ENGINE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [11:0] req_code,
  input  logic [1:0]  req_mode,
  input  logic        idle_low,
  input  logic        abort,
  output logic        ser_cs_n,
  output logic        ser_clk,
  output logic        ser_dat,
  output logic        done
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_CYC);

  seq_st_t          state;
  logic [CMD_W-1:0] word_q;
  logic             cs_q, done_q;
  logic [GW-1:0]    hi_cnt;
  logic [7:0]       raw_byte, tx_byte;
  logic             tx_fin;

  // named events
  wire accept    = req_valid && (state == S_IDLE);
  wire abort_hit = abort && (state != S_IDLE);
  wire frame_go  = (state == S_GAP) && cs_q && (hi_cnt == GAP_V);
  wire byte2_go  = (state == S_B0) && tx_fin;
  wire tx_start  = frame_go || byte2_go;
  wire frame_end = (state == S_B1) && tx_fin && !abort;

  assign raw_byte = (state == S_GAP) ? word_q[15:8] : word_q[7:0];

  generate
    if (LSB_ENGINE) begin : g_mirror
      assign tx_byte = rev_byte(raw_byte);
    end else begin : g_plain
      assign tx_byte = raw_byte;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; word_q <= '0; cs_q <= 1'b1; done_q <= 1'b0; hi_cnt <= '0;
    end else begin
      done_q <= frame_end;
      hi_cnt <= cs_q ? ((hi_cnt == GAP_V) ? GAP_V : hi_cnt + GW'(1)) : '0;
      if (abort_hit) begin
        state <= S_IDLE; cs_q <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (accept) begin
            word_q <= pack_cmd(req_mode, req_code);
            cs_q   <= 1'b1;
            state  <= S_GAP;
          end
          S_GAP: if (frame_go) begin
            cs_q <= 1'b0; state <= S_B0;
          end
          S_B0: if (tx_fin) state <= S_B1;
          S_B1: if (tx_fin) begin
            cs_q  <= !idle_low;
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  dacw_byte_tx #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .LSB_FIRST(LSB_ENGINE)) u_tx (
    .clk(clk), .rst_n(rst_n), .kill(abort_hit), .start(tx_start),
    .byte_in(tx_byte), .sclk(ser_clk), .sdat(ser_dat), .fin(tx_fin)
  );

  assign req_ready = (state == S_IDLE);
  assign ser_cs_n  = cs_q;
  assign done      = done_q;

  p_strobe_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_cs_n) |-> hi_cnt == GAP_V);
  p_clk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |-> !ser_clk);
  p_rise_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> !ser_cs_n);
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !req_ready |=> ser_cs_n && !ser_clk && req_ready && !done);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_dacw_seq.sv
`timescale 1ns/1ps
module tb_dacw_seq;
  localparam int HI = 2, LO = 3, GAP = 7;
  // {mode, code, idle_low}
  localparam logic [14:0] VEC [0:5] = '{
    {2'd0, 12'hABC, 1'b0}, {2'd1, 12'hFFF, 1'b0}, {2'd2, 12'h000, 1'b1},
    {2'd3, 12'h5A5, 1'b1}, {2'd0, 12'h800, 1'b0}, {2'd2, 12'h7FF, 1'b0}};

  logic clk = 0, rst_n = 0, req_valid = 0, idle_low = 0, abort = 0;
  logic [11:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, ser_cs_n, ser_clk, ser_dat, done;
  logic m_ready, m_cs_n, m_clk, m_dat, m_done;
  always #4 clk = ~clk;

  dacw_seq #(.HI_CYC(HI), .LO_CYC(LO), .GAP_CYC(GAP), .LSB_ENGINE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .idle_low(idle_low), .abort(abort),
    .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .done(done));
  dacw_seq #(.HI_CYC(HI), .LO_CYC(LO), .GAP_CYC(GAP), .LSB_ENGINE(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(m_ready),
    .req_code(req_code), .req_mode(req_mode), .idle_low(idle_low), .abort(abort),
    .ser_cs_n(m_cs_n), .ser_clk(m_clk), .ser_dat(m_dat), .done(m_done));

  int checks = 0, fails = 0;
  int rx_bits = 0, rx_cnt = 0, discards = 0, done_cnt = 0;
  int hr = 0, lr = 0, ch = 0, min_hi = 1000, min_lo = 1000, min_gap = 1000;
  int bad_idle = 0, mism = 0;
  logic lo_valid = 0, prev_clk = 0, prev_cs = 1;
  logic [15:0] rx_sh = '0, rx_word = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line receiver and timing monitor, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (!ser_cs_n && prev_clk && !ser_clk) begin
      rx_sh = {rx_sh[14:0], ser_dat};
      rx_bits++;
      if (rx_bits == 16) begin rx_word = rx_sh; rx_cnt++; end
    end
    if (!prev_cs && ser_cs_n) begin
      if (rx_bits != 0 && rx_bits < 16) discards++;
      rx_bits = 0;
    end
    if (prev_cs && !ser_cs_n) rx_bits = 0;
    if (ser_clk) hr++;
    else begin
      if (prev_clk && !ser_cs_n && hr < min_hi) min_hi = hr;
      hr = 0;
    end
    if (!ser_clk && !ser_cs_n) lr++;
    if (ser_clk && !prev_clk) begin
      if (lo_valid && lr < min_lo) min_lo = lr;
      lr = 0; lo_valid = 1;
    end
    if (ser_cs_n) begin lo_valid = 0; lr = 0; end
    if (ser_cs_n) ch++;
    else begin
      if (prev_cs && ch < min_gap) min_gap = ch;
      ch = 0;
    end
    if (ser_cs_n && ser_clk) bad_idle++;
    if ({ser_cs_n, ser_clk, ser_dat} != {m_cs_n, m_clk, m_dat}) mism++;
    if (done) done_cnt++;
    prev_clk = ser_clk; prev_cs = ser_cs_n;
  end

  task automatic send(input logic [1:0] m, input logic [11:0] c, input logic il);
    @(negedge clk);
    req_mode = m; req_code = c; idle_low = il; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_done(output bit ok);
    int d0;
    d0 = done_cnt; ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done_cnt != d0) begin ok = 1; break; end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int rc0, dc0, dsc0;
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_cs_n == 1, "R1 cs_n in reset", ser_cs_n, 1);
    chk(ser_clk == 0, "R1 clk in reset", ser_clk, 0);
    chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
    chk(done == 0, "R1 done in reset", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      rc0 = rx_cnt; dc0 = done_cnt;
      send(VEC[i][14:13], VEC[i][12:1], VEC[i][0]);
      wait_done(ok);
      exp = {2'b00, VEC[i][14:13], VEC[i][12:1]};
      chk(ok && done_cnt == dc0 + 1, "R11 one done per frame", done_cnt - dc0, 1);
      chk(rx_cnt == rc0 + 1, "R3 16 falling edges received", rx_cnt - rc0, 1);
      chk(rx_word == exp, "R2 received word", rx_word, exp);
      chk(req_ready == 1, "R9 ready back with done", req_ready, 1);
      chk(ser_cs_n == !VEC[i][0], "R7 strobe state after frame", ser_cs_n, !VEC[i][0]);
    end

    // R10 abort in the middle of the first byte
    idle_low = 0;
    @(negedge clk);
    rc0 = rx_cnt; dc0 = done_cnt; dsc0 = discards;
    send(2'd1, 12'h123, 1'b0);
    for (int k = 0; k < 2000 && rx_bits < 5; k++) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(ser_cs_n == 1, "R10 strobe high after abort", ser_cs_n, 1);
    chk(ser_clk == 0, "R10 clock low after abort", ser_clk, 0);
    chk(req_ready == 1, "R10 ready after abort", req_ready, 1);
    repeat (40) @(negedge clk);
    chk(done_cnt == dc0, "R10 no done on abort", done_cnt - dc0, 0);
    chk(discards == dsc0 + 1, "R10 partial frame discarded", discards - dsc0, 1);
    chk(rx_cnt == rc0, "R10 no word delivered", rx_cnt - rc0, 0);

    // R10 abort while idle changes nothing
    abort = 1;
    @(negedge clk);
    abort = 0;
    @(negedge clk);
    chk(ser_cs_n == 1 && req_ready == 1, "R10 idle abort ignored", {ser_cs_n, req_ready}, 3);

    // a frame after the abort still completes
    rc0 = rx_cnt;
    send(2'd3, 12'h9C3, 1'b0);
    wait_done(ok);
    chk(ok && rx_word == 16'h39C3, "R2 word after abort", rx_word, 16'h39C3);

    repeat (5) @(negedge clk);
    chk(min_hi >= HI, "R5 min clock high", min_hi, HI);
    chk(min_lo >= LO, "R5 min clock low", min_lo, LO);
    chk(min_gap >= GAP, "R6 min strobe high before frame", min_gap, GAP);
    chk(bad_idle == 0, "R4 clock high while strobe high", bad_idle, 0);
    chk(mism == 0, "R8 mirrored engine waveform", mism, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule